// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a physical address. It reads a two-level page table that sits in ordinary memory. A caller hands over one request at a time: the virtual address, plus two qualifiers. One says whether the access is a store or a load. The other says whether it comes from user or supervisor code. The block then starts from a table-base input and reads one word of the first-level table. If that entry is present, it reads one word of the second-level table named by that entry. The result is either a physical address or a fault code.

Pages are 4 KB. The virtual address is split into three fields:
- bits 31:22 index the first level, where each entry spans 4 MB;
- bits 21:12 index the second level, where each entry spans 4 KB;
- bits 11:0 are the byte offset, which passes through unchanged.

Every table entry is a 32-bit word with this layout:
- bits 31:12 hold a frame number;
- bit 0 means present;
- bit 1 means stores allowed;
- bit 2 means user access allowed.

At the first level, the frame number is the base of the second-level table. At the second level, it is the physical frame.

The memory port is a plain read channel. The block raises a request strobe for one cycle with a word address. Memory then returns one data word, with a valid strobe, any number of cycles later (at least one).

Top module: `xlate_walker`

## Requirements
- R1: Out of reset, `reqReady` is 1 and `rspValid` and `memReqValid` are 0. A request is accepted when `reqValid` and `reqReady` are both 1. `reqReady` stays 0 from the cycle after acceptance through the result cycle.
- R2: The first memory read addresses `tableBase + 4 * vaddr[31:22]`. It is issued in the cycle right after acceptance.
- R3: The second memory read addresses `{entry1[31:12], 12'h000} + 4 * vaddr[21:12]`, where entry1 is the first-level word returned.
- R4: Each table read is a single-cycle `memReqValid` pulse. The walker waits for `memRspValid` however long it takes and issues at most two reads per request.
- R5: A first-level word with bit 0 clear ends the walk after one read. The result carries fault code 1 (not present) and `rspPaddr` = 0.
- R6: A second-level word with bit 0 clear gives fault code 1, even when the permission bits would also have refused the access. `rspPaddr` is 0 on every fault.
- R7: A store (`reqWrite`=1) where bit 1 is clear in either the first-level or the second-level word gives fault code 2 (protection). A load ignores bit 1.
- R8: A user access (`reqUser`=1) where bit 2 is clear in either word gives fault code 2. A supervisor access ignores bit 2.
- R9: A walk with no fault returns fault code 0 and `rspPaddr = {entry2[31:12], vaddr[11:0]}`.
- R10: `rspValid` is a one-cycle pulse. It arrives in the cycle after the final `memRspValid`. `reqReady` is 1 again in the cycle after that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tableBase | input | 32 | Byte address of the first-level table; held stable during a walk |
| reqValid | input | 1 | Translation request strobe |
| reqReady | output | 1 | Walker idle, request can be taken |
| reqVaddr | input | 32 | Virtual address to translate |
| reqWrite | input | 1 | 1 = store access, 0 = load |
| reqUser | input | 1 | 1 = user access, 0 = supervisor |
| memReqValid | output | 1 | Table read request, one cycle |
| memReqAddr | output | 32 | Byte address of the table word |
| memRspValid | input | 1 | Table read data valid |
| memRspData | input | 32 | Table read data |
| rspValid | output | 1 | Result valid, one cycle |
| rspFault | output | 2 | 0 = ok, 1 = not present, 2 = protection |
| rspPaddr | output | 32 | Physical address, 0 on a fault |

## Verification
The bench sweeps 32 first-level indices against eight second-level indices, including the top index 1023. It runs all four store/user combinations over a table whose contents are computed arithmetically, and it varies memory latency by address.

It targets six kinds of mistake:
- A design that checks permissions on only one level would let a store through when only the first-level entry forbids it.
- One that ranks protection above absence would report code 2 for a missing second-level page.
- One that keeps walking past an absent first-level entry would show a second read.
- A wrong index field or a missing ×4 scale would fetch the wrong word and return the wrong frame.
- Leaking the frame on a fault would leave `rspPaddr` nonzero.
- An early or stretched result pulse is caught by the cycle count taken from the last memory response.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  localparam int PteBitValid = 0;
  localparam int PteBitWrite = 1;
  localparam int PteBitUser  = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH_L1,
    ST_WAIT_L1,
    ST_FETCH_L2,
    ST_WAIT_L2,
    ST_DONE,
    ST_FAULT
  } walkState_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_PAGE = 2'd1,
    FLT_PROT = 2'd2
  } fault_e;

  // control -> datapath strobes
  typedef struct packed {
    logic capReq;    // capture request fields
    logic selL2;     // address mux: second-level entry
    logic latchL1;   // store first-level entry
    logic latchL2;   // store final frame number
    logic showAddr;  // drive physical address on result
  } dpCtl_t;

  // datapath -> control status
  typedef struct packed {
    logic present;   // returned word has valid bit set
    logic permOk;    // access allowed by both levels
  } dpSts_t;

endpackage

// File: rtl/xlate_dp.sv
module xlate_dp
  import xlate_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] tableBase,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic              reqWrite,
  input  logic              reqUser,
  input  logic [ADDR_W-1:0] memRspData,
  output logic [ADDR_W-1:0] memReqAddr,
  output dpSts_t            sts,
  output logic [ADDR_W-1:0] rspPaddr
);

  localparam int FrameW = ADDR_W - OFF_W;
  localparam int PadW   = ADDR_W - IDX_W - 2;

  logic [ADDR_W-1:0] vaddrQ;
  logic              writeQ;
  logic              userQ;
  logic [FrameW-1:0] l1FrameQ;
  logic              l1WriteQ;
  logic              l1UserQ;
  logic [FrameW-1:0] frameQ;

  logic [IDX_W-1:0]  vpnHi;
  logic [IDX_W-1:0]  vpnLo;
  logic [ADDR_W-1:0] l1Addr;
  logic [ADDR_W-1:0] l2Addr;
  logic              unusedRspBits;

  assign vpnHi = vaddrQ[ADDR_W-1 -: IDX_W];
  assign vpnLo = vaddrQ[OFF_W +: IDX_W];

  assign l1Addr = tableBase + {{PadW{1'b0}}, vpnHi, 2'b00};
  assign l2Addr = {l1FrameQ, {OFF_W{1'b0}}} + {{PadW{1'b0}}, vpnLo, 2'b00};
  assign memReqAddr = ctl.selL2 ? l2Addr : l1Addr;

  assign unusedRspBits = ^memRspData[OFF_W-1:PteBitUser+1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaddrQ   <= '0;
      writeQ   <= 1'b0;
      userQ    <= 1'b0;
      l1FrameQ <= '0;
      l1WriteQ <= 1'b0;
      l1UserQ  <= 1'b0;
      frameQ   <= '0;
    end else begin
      if (ctl.capReq) begin
        vaddrQ <= reqVaddr;
        writeQ <= reqWrite;
        userQ  <= reqUser;
      end
      if (ctl.latchL1) begin
        l1FrameQ <= memRspData[ADDR_W-1:OFF_W];
        l1WriteQ <= memRspData[PteBitWrite];
        l1UserQ  <= memRspData[PteBitUser];
      end
      if (ctl.latchL2) begin
        frameQ <= memRspData[ADDR_W-1:OFF_W];
      end
    end
  end

  always_comb begin
    sts.present = memRspData[PteBitValid];
    sts.permOk  = !(writeQ && !(l1WriteQ && memRspData[PteBitWrite])) &&
                  !(userQ  && !(l1UserQ  && memRspData[PteBitUser]));
  end

  assign rspPaddr = ctl.showAddr ? {frameQ, vaddrQ[OFF_W-1:0]} : '0;

endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       memRspValid,
  input  dpSts_t     sts,
  output dpCtl_t     ctl,
  output logic       reqReady,
  output logic       memReqValid,
  output logic       rspValid,
  output logic [1:0] rspFault
);

  walkState_e stateQ, stateD;
  fault_e     faultQ, faultD;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      faultQ <= FLT_NONE;
    end else begin
      stateQ <= stateD;
      faultQ <= faultD;
    end
  end

  always_comb begin
    stateD = stateQ;
    faultD = faultQ;
    case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          stateD = ST_FETCH_L1;
          faultD = FLT_NONE;
        end
      end
      ST_FETCH_L1: stateD = ST_WAIT_L1;
      ST_WAIT_L1: begin
        if (memRspValid) begin
          if (!sts.present) begin
            stateD = ST_FAULT;
            faultD = FLT_PAGE;
          end else begin
            stateD = ST_FETCH_L2;
          end
        end
      end
      ST_FETCH_L2: stateD = ST_WAIT_L2;
      ST_WAIT_L2: begin
        if (memRspValid) begin
          if (!sts.present) begin
            stateD = ST_FAULT;
            faultD = FLT_PAGE;
          end else if (!sts.permOk) begin
            stateD = ST_FAULT;
            faultD = FLT_PROT;
          end else begin
            stateD = ST_DONE;
          end
        end
      end
      ST_DONE:  stateD = ST_IDLE;
      ST_FAULT: stateD = ST_IDLE;
      default:  stateD = ST_IDLE;
    endcase
  end

  always_comb begin
    ctl.capReq   = (stateQ == ST_IDLE) && reqValid;
    ctl.selL2    = (stateQ == ST_FETCH_L2);
    ctl.latchL1  = (stateQ == ST_WAIT_L1) && memRspValid;
    ctl.latchL2  = (stateQ == ST_WAIT_L2) && memRspValid;
    ctl.showAddr = (stateQ == ST_DONE);
  end

  assign reqReady    = (stateQ == ST_IDLE);
  assign memReqValid = (stateQ == ST_FETCH_L1) || (stateQ == ST_FETCH_L2);
  assign rspValid    = (stateQ == ST_DONE) || (stateQ == ST_FAULT);
  assign rspFault    = rspValid ? faultQ : FLT_NONE;

endmodule

// File: rtl/xlate_walker.sv
module xlate_walker
  import xlate_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] tableBase,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic              reqWrite,
  input  logic              reqUser,
  output logic              memReqValid,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [ADDR_W-1:0] memRspData,
  output logic              rspValid,
  output logic [1:0]        rspFault,
  output logic [ADDR_W-1:0] rspPaddr
);

  dpCtl_t ctl;
  dpSts_t sts;

  xlate_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .memRspValid(memRspValid),
    .sts        (sts),
    .ctl        (ctl),
    .reqReady   (reqReady),
    .memReqValid(memReqValid),
    .rspValid   (rspValid),
    .rspFault   (rspFault)
  );

  xlate_dp #(
    .ADDR_W(ADDR_W),
    .IDX_W (IDX_W),
    .OFF_W (OFF_W)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .tableBase (tableBase),
    .reqVaddr  (reqVaddr),
    .reqWrite  (reqWrite),
    .reqUser   (reqUser),
    .memRspData(memRspData),
    .memReqAddr(memReqAddr),
    .sts       (sts),
    .rspPaddr  (rspPaddr)
  );

endmodule

// File: rtl/xlate_walker_chk.sv
module xlate_walker_chk #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] tableBase,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] reqVaddr,
  input logic              memReqValid,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              memRspValid,
  input logic              rspValid,
  input logic [1:0]        rspFault,
  input logic [ADDR_W-1:0] rspPaddr
);

  localparam int PadW = ADDR_W - IDX_W - 2;

  logic [ADDR_W-1:0] vaQ;
  logic              accQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaQ  <= '0;
      accQ <= 1'b0;
    end else begin
      accQ <= reqValid && reqReady;
      if (reqValid && reqReady) vaQ <= reqVaddr;
    end
  end

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid || rspValid) |-> !reqReady); // R1

  AST_L1_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    accQ |-> (memReqValid &&
              memReqAddr == tableBase + {{PadW{1'b0}}, vaQ[ADDR_W-1 -: IDX_W], 2'b00})); // R2

  AST_MEMREQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid); // R4

  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault != 2'd0) |-> (rspPaddr == '0)); // R5

  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault == 2'd0) |-> (rspPaddr[OFF_W-1:0] == vaQ[OFF_W-1:0])); // R9

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> (!rspValid && reqReady)); // R10

  AST_RSP_AFTER_MEM: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(memRspValid)); // R10

endmodule

bind xlate_walker xlate_walker_chk #(
  .ADDR_W(ADDR_W),
  .IDX_W (IDX_W),
  .OFF_W (OFF_W)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .tableBase  (tableBase),
  .reqValid   (reqValid),
  .reqReady   (reqReady),
  .reqVaddr   (reqVaddr),
  .memReqValid(memReqValid),
  .memReqAddr (memReqAddr),
  .memRspValid(memRspValid),
  .rspValid   (rspValid),
  .rspFault   (rspFault),
  .rspPaddr   (rspPaddr)
);

// File: tb/xlate_walker_test.sv
module xlate_walker_test;

  localparam logic [31:0] BASE   = 32'h0010_0000;
  localparam logic [31:0] L2LO   = 32'h0020_0000;
  localparam logic [31:0] L2HI   = 32'h0060_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] tableBase = BASE;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVaddr = '0;
  logic        reqWrite = 1'b0;
  logic        reqUser = 1'b0;
  logic        memReqValid;
  logic [31:0] memReqAddr;
  logic        memRspValid;
  logic [31:0] memRspData;
  logic        rspValid;
  logic [1:0]  rspFault;
  logic [31:0] rspPaddr;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int lastRspCyc = 0;
  int rdCount = 0;
  logic [31:0] rdAddr [2];

  always #4 clk = ~clk;

  xlate_walker uut (
    .clk        (clk),
    .rstN       (rstN),
    .tableBase  (tableBase),
    .reqValid   (reqValid),
    .reqReady   (reqReady),
    .reqVaddr   (reqVaddr),
    .reqWrite   (reqWrite),
    .reqUser    (reqUser),
    .memReqValid(memReqValid),
    .memReqAddr (memReqAddr),
    .memRspValid(memRspValid),
    .memRspData (memRspData),
    .rspValid   (rspValid),
    .rspFault   (rspFault),
    .rspPaddr   (rspPaddr)
  );

  function automatic logic [31:0] pte1(int i);
    logic [19:0] fr = 20'(32'h200 + i);
    logic v = (i % 7) != 3;
    logic w = (i % 5) != 1;
    logic u = (i % 3) != 2;
    return {fr, 9'b0, u, w, v};
  endfunction

  function automatic logic [31:0] pte2(int i, int j);
    logic [19:0] fr = 20'((i * 37 + j * 13 + 5) & 32'hFFFFF);
    logic v = ((i + j) % 11) != 4;
    logic w = ((j % 2) == 0) || ((i % 4) == 0);
    logic u = (j % 3) != 1;
    return {fr, 9'b0, u, w, v};
  endfunction

  function automatic logic [31:0] memRead(logic [31:0] a);
    if (a >= BASE && a < BASE + 32'd4096 && a[1:0] == 2'b00)
      return pte1(int'((a - BASE) >> 2));
    else if (a >= L2LO && a < L2HI && a[1:0] == 2'b00)
      return pte2(int'(a >> 12) - 32'h200, int'((a >> 2) & 32'h3FF));
    return 32'h0;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
    end
  end

  // memory model: latency 1..3 cycles depending on address
  initial begin
    int cnt = 0;
    logic [31:0] pend = '0;
    memRspValid = 1'b0;
    memRspData  = '0;
    forever begin
      @(negedge clk);
      memRspValid = 1'b0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          memRspValid = 1'b1;
          memRspData  = memRead(pend);
          lastRspCyc  = cyc;
        end
      end else if (memReqValid) begin
        pend = memReqAddr;
        if (rdCount < 2) rdAddr[rdCount] = memReqAddr;
        rdCount++;
        cnt = 1 + int'((memReqAddr >> 2) % 3);
      end
    end
  end

  task automatic xlate(int i, int j, logic [11:0] off, bit wr, bit us);
    logic [31:0] va = {10'(i), 10'(j), off};
    logic [31:0] e1 = pte1(i);
    logic [31:0] e2 = pte2(i, j);
    logic [1:0]  expF;
    logic [31:0] expP;
    int expReads;
    bit got;
    string tag;
    if (!e1[0]) begin
      expF = 2'd1; expP = 0; expReads = 1; tag = "R5";
    end else if (!e2[0]) begin
      expF = 2'd1; expP = 0; expReads = 2; tag = "R6";
    end else if (wr && !(e1[1] && e2[1])) begin
      expF = 2'd2; expP = 0; expReads = 2; tag = "R7";
    end else if (us && !(e1[2] && e2[2])) begin
      expF = 2'd2; expP = 0; expReads = 2; tag = "R8";
    end else begin
      expF = 2'd0; expP = {e2[31:12], off}; expReads = 2; tag = "R9";
    end
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    rdCount  = 0;
    reqVaddr = va;
    reqWrite = wr;
    reqUser  = us;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check(reqReady == 1'b0, "R1 busy", 32'(reqReady), 32'd0);
    got = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (rspValid) begin got = 1; break; end
    end
    check(got, "R10 result seen", 32'(got), 32'd1);
    if (got) begin
      check(cyc == lastRspCyc + 1, "R10 timing", 32'(cyc), 32'(lastRspCyc + 1));
      check(rspFault == expF, tag, 32'(rspFault), 32'(expF));
      check(rspPaddr == expP, tag, rspPaddr, expP);
      check(rdCount == expReads, "R4 read count", 32'(rdCount), 32'(expReads));
      check(rdAddr[0] == BASE + 32'(i * 4), "R2 L1 addr", rdAddr[0], BASE + 32'(i * 4));
      if (expReads == 2)
        check(rdAddr[1] == {e1[31:12], 12'h000} + 32'(j * 4), "R3 L2 addr",
              rdAddr[1], {e1[31:12], 12'h000} + 32'(j * 4));
      @(negedge clk);
      check(!rspValid && reqReady, "R10 pulse end", {30'b0, rspValid, reqReady}, 32'h1);
    end
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=<180000 cycles", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int jl [8] = '{0, 1, 2, 3, 4, 5, 6, 1023};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1, "R1 reset ready", 32'(reqReady), 32'd1);
    check(rspValid == 1'b0, "R1 reset rsp", 32'(rspValid), 32'd0);
    check(memReqValid == 1'b0, "R1 reset memreq", 32'(memReqValid), 32'd0);
    for (int i = 0; i < 32; i++) begin
      for (int jj = 0; jj < 8; jj++) begin
        for (int m = 0; m < 4; m++) begin
          xlate(i, jl[jj], 12'((i * 97 + jl[jj] * 31 + m * 1365) & 32'hFFF), m[0], m[1]);
        end
      end
    end
    xlate(1023, 1023, 12'hFFF, 1'b0, 1'b0);
    xlate(1020, 0, 12'h000, 1'b1, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule